// File: doc/BRIEF.md
# Grouped Clear-on-Read Interrupt Controller

This block gathers twenty-four event lines, arranged as three groups of eight, into one active-low interrupt request for a host. Group 0 carries packet-handler events, group 1 carries chip-status events and group 2 carries modem events. Every line is watched for a rising edge, and each edge latches a pending flag whatever the enables say. The request goes low while at least one pending flag has both its own enable and its group's enable set.

The host reads through a strobe and a select code. Code 0 reads every group. Codes 1 to 3 read group 0, 1 or 2 alone. Code 4 is a fast, non-destructive peek. The answer arrives one clock after the strobe and holds two things: the pending flags the read covers, and the present level of those same source lines (live status), whether or not they are enabled. When clear-on-read is switched on, the full read and the group reads clear exactly the flags they returned. The peek never clears anything.

Inside, a read-control state machine has four states. RC_IDLE means no answer is presented. RC_FULL, RC_GROUP and RC_PEEK each present an answer of that kind. From any state, a strobe with code 0 moves it to RC_FULL, codes 1 to 3 move it to RC_GROUP and code 4 moves it to RC_PEEK. A cycle with no strobe, or with code 5 to 7, moves it to RC_IDLE. The request output comes from a second machine with two states. IRQ_QUIET moves to IRQ_RAISED when the updated flags hold an enabled pending bit. IRQ_RAISED moves back to IRQ_QUIET when none is left.

Top module: `grp_intc_top`

## Requirements
- R1: Source bit g*8+i is line i of group g (0 packet handler, 1 chip status, 2 modem). Its pending flag sets at a clock edge where the line is high and was low at the previous edge.
- R2: At each clock edge, irq_n_o is driven low if any pending flag, after that edge's update, has both its src_en_i bit and its grp_en_i bit set. Otherwise it is driven high.
- R3: A strobe with code 0 produces rd_valid_o=1 in the next cycle. rd_pend_o then holds all 24 flags as they were in the strobe cycle. With cor_en_i=1, all 24 flags are cleared.
- R4: A strobe with code g+1 (g = 0..2) returns group g's flags in bits g*8+7..g*8 and zeros in every other bit. With cor_en_i=1, it clears only group g.
- R5: rd_live_o returns the levels of src_i in the strobe cycle for the bits the read covers (all 24 for codes 0 and 4, group g for code g+1), whatever the enables.
- R6: A strobe with code 4 returns all flags and live levels, clears no flag and leaves irq_n_o as the flags and enables alone would make it.
- R7: A rising edge that arrives in the same cycle as a clearing read of that bit leaves the bit set.
- R8: With cor_en_i=0, reads with code 0 and codes 1 to 3 leave every flag set.
- R9: irq_n_o goes high at the clock edge of a clearing read that leaves no enabled pending flag.
- R10: Flags latch while their source or group is disabled. Enabling them later drives irq_n_o low at the next edge.
- R11: A strobe with code 5, 6 or 7 gives no answer (rd_valid_o=0 next cycle) and clears nothing. rd_valid_o is 0 in the cycle after any cycle with no strobe.
- R12: While rst_n is low, all flags are 0, irq_n_o is 1, rd_valid_o is 0 and both read buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 24 | Event lines, group g in bits g*8+7..g*8 |
| src_en_i | input | 24 | Per-source interrupt enables |
| grp_en_i | input | 3 | Per-group interrupt enables |
| cor_en_i | input | 1 | Clear-on-read enable for codes 0 to 3 |
| rd_stb_i | input | 1 | Read strobe |
| rd_sel_i | input | 3 | Read code: 0 full, 1..3 group, 4 peek |
| irq_n_o | output | 1 | Interrupt request, active low |
| rd_valid_o | output | 1 | Read answer valid |
| rd_pend_o | output | 24 | Pending flags returned |
| rd_live_o | output | 24 | Live source levels returned |

## Verification
A flag that is lost or wrongly set inside the block shows up in the next read that covers it, and in irq_n_o at the very next edge if its enables are on. Because the bench peeks often, no flag error stays hidden for more than a few cycles. A read-control state that leaves the wrong kind of answer, or that clears on a peek or with clear-on-read off, shows up one cycle later in rd_pend_o, rd_live_o or rd_valid_o. The bench model compares all four outputs on every clock, during both directed sequences and a long random phase.

// File: rtl/grp_intc_pkg.sv
package grp_intc_pkg;

    typedef enum logic [1:0] {
        RC_IDLE,
        RC_FULL,
        RC_GROUP,
        RC_PEEK
    } rd_state_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/grp_intc_bank.sv
module grp_intc_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] src_en,
    input  logic         grp_en,
    input  logic         clr,
    output logic [W-1:0] pend,
    output logic         any_act_nxt
);

    logic [W-1:0] src_q;
    logic [W-1:0] rise;
    logic [W-1:0] pend_nxt;

    // A new edge wins over a clear in the same cycle.
    always_comb begin
        rise        = src & ~src_q;
        pend_nxt    = (pend & ~{W{clr}}) | rise;
        any_act_nxt = grp_en & (|(pend_nxt & src_en));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            pend  <= '0;
        end else begin
            src_q <= src;
            pend  <= pend_nxt;
        end
    end

endmodule

// File: rtl/grp_intc_rdctl.sv
module grp_intc_rdctl
    import grp_intc_pkg::*;
#(
    parameter int NG = 3,
    parameter int W  = 8,
    parameter int SW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  logic [SW-1:0]   rd_sel,
    input  logic            cor_en,
    input  logic [NG*W-1:0] pend_all,
    input  logic [NG*W-1:0] src_all,
    output logic [NG-1:0]   clr_grp,
    output logic            rd_valid,
    output logic [NG*W-1:0] rd_pend,
    output logic [NG*W-1:0] rd_live
);

    localparam int TOT = NG * W;
    localparam logic [SW-1:0] SEL_FULL = '0;
    localparam logic [SW-1:0] SEL_PEEK = SW'(NG + 1);
    localparam logic [SW-1:0] SEL_LAST_GRP = SW'(NG);

    rd_state_e state_q, state_d;
    logic [TOT-1:0] mask_d;
    logic [TOT-1:0] pend_q, live_q;

    // Next state, read coverage mask and clear requests.
    always_comb begin
        state_d = RC_IDLE;
        mask_d  = '0;
        clr_grp = '0;
        if (rd_stb) begin
            if (rd_sel == SEL_FULL) begin
                state_d = RC_FULL;
                mask_d  = '1;
                clr_grp = {NG{cor_en}};
            end else if (rd_sel == SEL_PEEK) begin
                state_d = RC_PEEK;
                mask_d  = '1;
            end else if (rd_sel <= SEL_LAST_GRP) begin
                state_d = RC_GROUP;
                for (int g = 0; g < NG; g++) begin
                    if (rd_sel == SW'(g + 1)) begin
                        mask_d[g*W +: W] = '1;
                        clr_grp[g]       = cor_en;
                    end
                end
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Answer capture: values seen in the strobe cycle, before any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            live_q <= '0;
        end else if (state_d != RC_IDLE) begin
            pend_q <= pend_all & mask_d;
            live_q <= src_all & mask_d;
        end
    end

    // Outputs.
    always_comb begin
        rd_pend = pend_q;
        rd_live = live_q;
        unique case (state_q)
            RC_IDLE:                    rd_valid = 1'b0;
            RC_FULL, RC_GROUP, RC_PEEK: rd_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/grp_intc_irq.sv
module grp_intc_irq
    import grp_intc_pkg::*;
#(
    parameter int NG = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] grp_act_nxt,
    output logic          irq_n
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (|grp_act_nxt)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!(|grp_act_nxt)) state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_QUIET:  irq_n = 1'b1;
            IRQ_RAISED: irq_n = 1'b0;
        endcase
    end

endmodule

// File: rtl/grp_intc_top.sv
module grp_intc_top #(
    parameter int NUM_GRP = 3,
    parameter int GRP_W   = 8,
    parameter int SEL_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*GRP_W-1:0] src_i,
    input  logic [NUM_GRP*GRP_W-1:0] src_en_i,
    input  logic [NUM_GRP-1:0]       grp_en_i,
    input  logic                     cor_en_i,
    input  logic                     rd_stb_i,
    input  logic [SEL_W-1:0]         rd_sel_i,
    output logic                     irq_n_o,
    output logic                     rd_valid_o,
    output logic [NUM_GRP*GRP_W-1:0] rd_pend_o,
    output logic [NUM_GRP*GRP_W-1:0] rd_live_o
);

    localparam int TOT = NUM_GRP * GRP_W;

    logic [TOT-1:0]     pend_all;
    logic [NUM_GRP-1:0] clr_grp;
    logic [NUM_GRP-1:0] grp_act_nxt;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
        grp_intc_bank #(.W(GRP_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (src_i[g*GRP_W +: GRP_W]),
            .src_en     (src_en_i[g*GRP_W +: GRP_W]),
            .grp_en     (grp_en_i[g]),
            .clr        (clr_grp[g]),
            .pend       (pend_all[g*GRP_W +: GRP_W]),
            .any_act_nxt(grp_act_nxt[g])
        );
    end

    grp_intc_rdctl #(.NG(NUM_GRP), .W(GRP_W), .SW(SEL_W)) u_rdctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb_i),
        .rd_sel  (rd_sel_i),
        .cor_en  (cor_en_i),
        .pend_all(pend_all),
        .src_all (src_i),
        .clr_grp (clr_grp),
        .rd_valid(rd_valid_o),
        .rd_pend (rd_pend_o),
        .rd_live (rd_live_o)
    );

    grp_intc_irq #(.NG(NUM_GRP)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_act_nxt(grp_act_nxt),
        .irq_n      (irq_n_o)
    );

endmodule

// File: rtl/grp_intc_chk.sv
module grp_intc_chk #(
    parameter int NG = 3,
    parameter int W  = 8,
    parameter int SW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_stb,
    input logic [SW-1:0]   rd_sel,
    input logic            cor_en,
    input logic [NG*W-1:0] src_all,
    input logic [NG*W-1:0] pend_all,
    input logic            irq_n,
    input logic            rd_valid,
    input logic [NG*W-1:0] rd_pend,
    input logic [NG*W-1:0] rd_live
);

    localparam int TOT = NG * W;
    localparam logic [SW-1:0] PEEK = SW'(NG + 1);

    function automatic logic [TOT-1:0] gmask(input logic [SW-1:0] s);
        gmask = '0;
        for (int g = 0; g < NG; g++) begin
            if (s == SW'(g + 1)) gmask[g*W +: W] = '1;
        end
    endfunction

    assert_irq_backed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|pend_all));

    assert_full_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel == '0) |=> (rd_valid && rd_pend == $past(pend_all)));

    assert_group_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel != '0 && rd_sel <= SW'(NG)) |=>
        (((rd_pend | rd_live) & ~gmask($past(rd_sel))) == '0));

    assert_live_peek_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel == PEEK) |=> (rd_live == $past(src_all)));

    assert_peek_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel == PEEK) |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

    assert_cor_off_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !cor_en) |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

    assert_no_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && rd_sel <= PEEK) |=> !rd_valid);

endmodule

bind grp_intc_top grp_intc_chk #(.NG(NUM_GRP), .W(GRP_W), .SW(SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb_i),
    .rd_sel  (rd_sel_i),
    .cor_en  (cor_en_i),
    .src_all (src_i),
    .pend_all(pend_all),
    .irq_n   (irq_n_o),
    .rd_valid(rd_valid_o),
    .rd_pend (rd_pend_o),
    .rd_live (rd_live_o)
);

// File: tb/sim_grp_intc_top.sv
`timescale 1ns/1ps
module sim_grp_intc_top;

    localparam int NG  = 3;
    localparam int W   = 8;
    localparam int TOT = NG * W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TOT-1:0] src = '0;
    logic [TOT-1:0] src_en = '0;
    logic [NG-1:0]  grp_en = '0;
    logic           cor_en = 1'b1;
    logic           rd_stb = 1'b0;
    logic [2:0]     rd_sel = '0;
    logic           irq_n;
    logic           rd_valid;
    logic [TOT-1:0] rd_pend;
    logic [TOT-1:0] rd_live;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [TOT-1:0] m_pend  = '0;
    logic [TOT-1:0] m_srcq  = '0;
    logic [TOT-1:0] m_rpend = '0;
    logic [TOT-1:0] m_rlive = '0;
    logic           m_irq_n = 1'b1;
    logic           m_valid = 1'b0;
    int             m_kind  = 0;

    always #2 clk = ~clk;

    grp_intc_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .src_en_i  (src_en),
        .grp_en_i  (grp_en),
        .cor_en_i  (cor_en),
        .rd_stb_i  (rd_stb),
        .rd_sel_i  (rd_sel),
        .irq_n_o   (irq_n),
        .rd_valid_o(rd_valid),
        .rd_pend_o (rd_pend),
        .rd_live_o (rd_live)
    );

    task automatic check(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Behavioural reference, updated at every edge from the bench-driven inputs.
    always @(posedge clk) begin : model
        logic [TOT-1:0] rise, clr, msk, en;
        if (!rst_n) begin
            m_pend = '0; m_srcq = '0; m_rpend = '0; m_rlive = '0;
            m_irq_n = 1'b1; m_valid = 1'b0;
        end else begin
            rise = src & ~m_srcq;
            clr = '0;
            msk = '0;
            if (rd_stb && rd_sel <= 3'd4) begin
                if (rd_sel == 3'd0 || rd_sel == 3'd4) msk = '1;
                else msk = {{(TOT-8){1'b0}}, 8'hFF} << (8 * (rd_sel - 1));
                if (cor_en && rd_sel != 3'd4) clr = msk;
                m_valid = 1'b1;
                m_rpend = m_pend & msk;
                m_rlive = src & msk;
                m_kind  = (rd_sel == 3'd0) ? 0 : (rd_sel == 3'd4) ? 2 : 1;
            end else begin
                m_valid = 1'b0;
            end
            m_pend = (m_pend & ~clr) | rise;
            m_srcq = src;
            en = '0;
            for (int g = 0; g < NG; g++) if (grp_en[g]) en[g*W +: W] = '1;
            en = en & src_en;
            m_irq_n = !(|(m_pend & en));
        end
    end

    // Compare every output on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check("R2 irq_n", {{(TOT-1){1'b0}}, irq_n}, {{(TOT-1){1'b0}}, m_irq_n});
            check("R11 rd_valid", {{(TOT-1){1'b0}}, rd_valid}, {{(TOT-1){1'b0}}, m_valid});
            if (m_kind == 0)      check("R3 rd_pend", rd_pend, m_rpend);
            else if (m_kind == 1) check("R4 rd_pend", rd_pend, m_rpend);
            else                  check("R6 rd_pend", rd_pend, m_rpend);
            check("R5 rd_live", rd_live, m_rlive);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R11 watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset irq_n", {{(TOT-1){1'b0}}, irq_n}, 1);
        check("R12 reset rd_valid", {{(TOT-1){1'b0}}, rd_valid}, 0);
        check("R12 reset rd_pend", rd_pend, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10: edge on a disabled source latches silently
        src[5] = 1'b1;
        @(negedge clk);
        check("R10 disabled source keeps irq_n high", {{(TOT-1){1'b0}}, irq_n}, 1);
        src[5] = 1'b0; rd_stb = 1'b1; rd_sel = 3'd4;
        @(negedge clk);
        check("R1 flag latched at bit 5", rd_pend, 24'h000020);
        check("R6 peek answer valid", {{(TOT-1){1'b0}}, rd_valid}, 1);
        rd_stb = 1'b0; src_en[5] = 1'b1; grp_en = 3'b001;
        @(negedge clk);
        check("R10 late enable raises irq", {{(TOT-1){1'b0}}, irq_n}, 0);

        // R3 / R9: clearing full read
        rd_stb = 1'b1; rd_sel = 3'd0;
        @(negedge clk);
        check("R3 full read returns flag", rd_pend, 24'h000020);
        check("R9 irq_n high after clearing read", {{(TOT-1){1'b0}}, irq_n}, 1);
        rd_stb = 1'b0;

        // R4: group read clears only its group
        src[10] = 1'b1; src[16] = 1'b1;
        @(negedge clk);
        src[10] = 1'b0; src[16] = 1'b0; rd_stb = 1'b1; rd_sel = 3'd2;
        @(negedge clk);
        check("R4 group 1 read", rd_pend, 24'h000400);
        rd_sel = 3'd4;
        @(negedge clk);
        check("R4 other group untouched", rd_pend, 24'h010000);

        // R7: edge in the same cycle as a clearing read
        rd_sel = 3'd0; src[3] = 1'b1;
        @(negedge clk);
        rd_sel = 3'd4;
        @(negedge clk);
        check("R7 edge survives clear", rd_pend, 24'h000008);
        src[3] = 1'b0;

        // R8: clear-on-read off
        cor_en = 1'b0; rd_sel = 3'd0;
        @(negedge clk);
        check("R8 first read", rd_pend, 24'h000008);
        @(negedge clk);
        check("R8 second read keeps flag", rd_pend, 24'h000008);
        cor_en = 1'b1;

        // R11: unused code
        rd_sel = 3'd5;
        @(negedge clk);
        check("R11 no answer for code 5", {{(TOT-1){1'b0}}, rd_valid}, 0);
        rd_sel = 3'd4;
        @(negedge clk);
        check("R11 code 5 cleared nothing", rd_pend, 24'h000008);
        rd_stb = 1'b0;

        // Random phase, checked by the model every clock
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            src = src ^ (TOT'($urandom) & TOT'($urandom) & TOT'($urandom));
            if ($urandom_range(0, 15) == 0) src_en = TOT'($urandom);
            if ($urandom_range(0, 15) == 0) grp_en = NG'($urandom);
            cor_en = ($urandom_range(0, 7) != 0);
            rd_stb = ($urandom_range(0, 9) < 3);
            rd_sel = 3'($urandom_range(0, 7));
        end
        @(negedge clk);
        rd_stb = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule